// File: doc/BRIEF.md
# Shift-Register Feistel Cipher Engine

This block is a 40-bit challenge-response cipher core. A one-cycle start strobe captures a 40-bit key and a 40-bit challenge. The core then runs 200 rounds, one per clock. Each round feeds a selection of key and challenge bits through a three-layer nonlinear function. The two-bit result, combined with the top two challenge bits, enters a challenge register that shifts toward bit 0. Every third round the key register steps as a linear feedback shift register. When the last round completes, a one-cycle done pulse marks the 24-bit response as valid.

The nonlinear function has three layers. The first holds sixteen leaf lookups, each addressed by five selected bits. The second holds four middle lookups, each addressed by four leaf outputs. The last is one final lookup, addressed by the four middle outputs, that yields two bits. All truth tables and the bit routing are parameters. The defaults are placeholder tables computed in the package, so a real table set can be dropped in without touching the datapath.

Top module: `fsr_cipher_core`

## Requirements
- R1: When the core is idle and `start` is high at a clock edge, that edge captures `key_in` and `challenge`, and round 0 runs on the next edge. The inputs are not sampled again during the run.
- R2: `done` is high for exactly one cycle, 200 clock edges after the capturing edge. It is low at every other time.
- R3: Each round shifts the challenge register right by two. New bit 39 is function output bit 1 XOR old bit 39, and new bit 38 is function output bit 0 XOR old bit 38.
- R4: The function output is computed from the layers in order. Leaf i reads five bits of the vector {key, challenge}, where challenge occupies indices 0..39 and key occupies indices 40..79, chosen by the routing table. Its five-bit address has pin 0 as the LSB. Leaves flagged as four-input (by default 14 and 15) use 0 for pin 4. Middle unit m is addressed by leaf outputs 4m..4m+3, with leaf 4m as the LSB. The final table is addressed by the middle outputs (unit 0 as the LSB), and its entry a occupies bits 2a+1:2a.
- R5: The key register steps only at the end of rounds whose index modulo 3 equals 1 (rounds 1, 4, 7, and so on, counting from 0). A step shifts the register left by one and sets new bit 0 to k39^k37^k20^k18. In all other rounds the key is unchanged.
- R6: An all-zero key stays all zero for the whole run.
- R7: `response` equals bits 23..0 of the challenge register after the final round. It holds that value until the next accepted start.
- R8: A `start` strobe that arrives while a run is in progress has no effect on the run, its timing or its response.
- R9: After reset, `done` is low and the core is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; ignored while busy |
| key_in | input | 40 | Key captured on an accepted start |
| challenge | input | 40 | Challenge captured on an accepted start |
| done | output | 1 | One-cycle pulse after the last round |
| response | output | 24 | Low 24 bits of the challenge register |

## Verification
A single wrong bit in the challenge or key register, whether from a misrouted leaf input, a swapped XOR position or a key step in the wrong round, spreads through the remaining rounds. It shows as a response mismatch at the done pulse, 200 cycles after start. It does not show earlier at the ports. A fault in the round counter or start handling shows sooner, as a done pulse at the wrong latency or a response tied to the ignored second challenge. The bench therefore compares every run against an independent round-by-round model and also checks the exact done latency.

// File: rtl/fsrc_pkg.sv
package fsrc_pkg;

    localparam int KW      = 40;
    localparam int CW      = 40;
    localparam int NLEAF   = 16;
    localparam int LEAF_IN = 5;
    localparam int NMID    = 4;
    localparam int VEC_W   = KW + CW;
    localparam int IDXW    = $clog2(VEC_W);
    localparam int LEAF_TW = 1 << LEAF_IN;
    localparam int MID_TW  = 16;
    localparam int FIN_TW  = 32;

    // key feedback taps
    localparam int TAP_A = 39;
    localparam int TAP_B = 37;
    localparam int TAP_C = 20;
    localparam int TAP_D = 18;

    localparam logic [NLEAF-1:0] FOUR_IN_DEF = 16'hC000;
    localparam logic [FIN_TW-1:0] FIN_TT_DEF  = 32'h4B2D_E1A7;

    function automatic logic [IDXW-1:0] route_of(int leaf, int pin);
        int nkey;
        if (FOUR_IN_DEF[leaf])
            nkey = 2;
        else
            nkey = (leaf % 2 == 0) ? 3 : 2;
        if (pin < nkey)
            return IDXW'(CW + ((leaf * 5 + pin * 13 + 7) % KW));
        else
            return IDXW'((leaf * 7 + pin * 11 + 3) % CW);
    endfunction

    function automatic logic [LEAF_TW-1:0] leaf_tt_of(int leaf);
        logic [31:0] t;
        t = 32'h9E37_79B9 * 32'(leaf + 1);
        t = t ^ {t[15:0], t[31:16]} ^ 32'h6996_C33C;
        return t;
    endfunction

    function automatic logic [MID_TW-1:0] mid_tt_of(int m);
        return 16'h6AC5 ^ 16'(16'h1F0B * (m + 3));
    endfunction

    function automatic logic [NLEAF*LEAF_TW-1:0] leaf_tt_all();
        logic [NLEAF*LEAF_TW-1:0] v;
        v = '0;
        for (int i = 0; i < NLEAF; i++) v[i*LEAF_TW +: LEAF_TW] = leaf_tt_of(i);
        return v;
    endfunction

    function automatic logic [NLEAF*LEAF_IN*IDXW-1:0] route_all();
        logic [NLEAF*LEAF_IN*IDXW-1:0] v;
        v = '0;
        for (int i = 0; i < NLEAF; i++)
            for (int j = 0; j < LEAF_IN; j++)
                v[(i*LEAF_IN + j)*IDXW +: IDXW] = route_of(i, j);
        return v;
    endfunction

    function automatic logic [NMID*MID_TW-1:0] mid_tt_all();
        logic [NMID*MID_TW-1:0] v;
        v = '0;
        for (int m = 0; m < NMID; m++) v[m*MID_TW +: MID_TW] = mid_tt_of(m);
        return v;
    endfunction

endpackage

// File: rtl/fsrc_leaf.sv
module fsrc_leaf
    import fsrc_pkg::*;
#(
    parameter logic [LEAF_TW-1:0] TT = '0
) (
    input  logic [LEAF_IN-1:0] addr,
    output logic               y
);
    always_comb y = TT[addr];
endmodule

// File: rtl/fsrc_round_fn.sv
module fsrc_round_fn
    import fsrc_pkg::*;
#(
    parameter logic [NLEAF*LEAF_TW-1:0]      LEAF_TT = leaf_tt_all(),
    parameter logic [NLEAF*LEAF_IN*IDXW-1:0] ROUTE   = route_all(),
    parameter logic [NLEAF-1:0]              FOUR_IN = FOUR_IN_DEF,
    parameter logic [NMID*MID_TW-1:0]        MID_TT  = mid_tt_all(),
    parameter logic [FIN_TW-1:0]             FIN_TT  = FIN_TT_DEF
) (
    input  logic [KW-1:0] key,
    input  logic [CW-1:0] chal,
    output logic [1:0]    y
);
    logic [VEC_W-1:0] vec;
    logic [NLEAF-1:0] leaf_y;
    logic [NMID-1:0]  mid_y;

    assign vec = {key, chal};

    for (genvar i = 0; i < NLEAF; i++) begin : g_leaf
        logic [LEAF_IN-1:0] addr;
        for (genvar j = 0; j < LEAF_IN; j++) begin : g_pin
            localparam logic [IDXW-1:0] IDX = ROUTE[(i*LEAF_IN + j)*IDXW +: IDXW];
            if (j == LEAF_IN - 1 && FOUR_IN[i]) begin : g_tied
                assign addr[j] = 1'b0;
            end else begin : g_live
                assign addr[j] = vec[IDX];
            end
        end
        fsrc_leaf #(.TT(LEAF_TT[i*LEAF_TW +: LEAF_TW])) i_leaf (
            .addr (addr),
            .y    (leaf_y[i])
        );
    end

    for (genvar m = 0; m < NMID; m++) begin : g_mid
        localparam logic [MID_TW-1:0] TT = MID_TT[m*MID_TW +: MID_TW];
        assign mid_y[m] = TT[leaf_y[4*m +: 4]];
    end

    always_comb y = FIN_TT[{mid_y, 1'b0} +: 2];
endmodule

// File: rtl/fsrc_key_step.sv
module fsrc_key_step
    import fsrc_pkg::*;
(
    input  logic [KW-1:0] key_cur,
    output logic [KW-1:0] key_nxt
);
    logic fb;
    always_comb begin
        fb      = key_cur[TAP_A] ^ key_cur[TAP_B] ^ key_cur[TAP_C] ^ key_cur[TAP_D];
        key_nxt = {key_cur[KW-2:0], fb};
    end
endmodule

// File: rtl/fsr_cipher_core.sv
module fsr_cipher_core
    import fsrc_pkg::*;
#(
    parameter int RESP_W     = 24,
    parameter int ROUNDS     = 200,
    parameter int KEY_PERIOD = 3,
    parameter int KEY_PHASE  = 1,
    parameter logic [NLEAF*LEAF_TW-1:0]      LEAF_TT = leaf_tt_all(),
    parameter logic [NLEAF*LEAF_IN*IDXW-1:0] ROUTE   = route_all(),
    parameter logic [NLEAF-1:0]              FOUR_IN = FOUR_IN_DEF,
    parameter logic [NMID*MID_TW-1:0]        MID_TT  = mid_tt_all(),
    parameter logic [FIN_TW-1:0]             FIN_TT  = FIN_TT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [KW-1:0]     key_in,
    input  logic [CW-1:0]     challenge,
    output logic              done,
    output logic [RESP_W-1:0] response
);
    localparam int CNTW = $clog2(ROUNDS);
    localparam int PHW  = $clog2(KEY_PERIOD + 1);
    localparam logic [CNTW-1:0] LAST_RND  = CNTW'(ROUNDS - 1);
    localparam logic [PHW-1:0]  LAST_PH   = PHW'(KEY_PERIOD - 1);
    localparam logic [PHW-1:0]  STEP_PH   = PHW'(KEY_PHASE);

    typedef struct packed {
        logic            busy;
        logic            done;
        logic [CNTW-1:0] rnd;
        logic [PHW-1:0]  phase;
        logic [KW-1:0]   key;
        logic [CW-1:0]   chal;
    } state_t;

    state_t state_d, state_q;
    logic [1:0]    rf_y;
    logic [KW-1:0] key_stepped;

    // named views of the state for the bound checker
    logic            run_q;
    logic [CNTW-1:0] rnd_q;
    logic [KW-1:0]   key_q;
    logic [CW-1:0]   chal_q;
    assign run_q  = state_q.busy;
    assign rnd_q  = state_q.rnd;
    assign key_q  = state_q.key;
    assign chal_q = state_q.chal;

    fsrc_round_fn #(
        .LEAF_TT (LEAF_TT),
        .ROUTE   (ROUTE),
        .FOUR_IN (FOUR_IN),
        .MID_TT  (MID_TT),
        .FIN_TT  (FIN_TT)
    ) i_round_fn (
        .key  (state_q.key),
        .chal (state_q.chal),
        .y    (rf_y)
    );

    fsrc_key_step i_key_step (
        .key_cur (state_q.key),
        .key_nxt (key_stepped)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (!state_q.busy) begin
            if (start) begin
                state_d.busy  = 1'b1;
                state_d.rnd   = '0;
                state_d.phase = '0;
                state_d.key   = key_in;
                state_d.chal  = challenge;
            end
        end else begin
            state_d.chal = {rf_y[1] ^ state_q.chal[CW-1],
                            rf_y[0] ^ state_q.chal[CW-2],
                            state_q.chal[CW-1:2]};
            if (state_q.phase == STEP_PH)
                state_d.key = key_stepped;
            state_d.phase = (state_q.phase == LAST_PH) ? '0 : state_q.phase + 1'b1;
            if (state_q.rnd == LAST_RND) begin
                state_d.busy = 1'b0;
                state_d.done = 1'b1;
            end else begin
                state_d.rnd = state_q.rnd + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign done     = state_q.done;
    assign response = state_q.chal[RESP_W-1:0];
endmodule

// File: rtl/fsrc_checker.sv
module fsrc_checker
    import fsrc_pkg::*;
#(
    parameter int CNTW       = 8,
    parameter int ROUNDS     = 200,
    parameter int KEY_PERIOD = 3,
    parameter int KEY_PHASE  = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [CW-1:0]   challenge,
    input logic            done,
    input logic            run_q,
    input logic [CNTW-1:0] rnd_q,
    input logic [KW-1:0]   key_q,
    input logic [CW-1:0]   chal_q
);
    localparam logic [CNTW-1:0] LAST_RND = CNTW'(ROUNDS - 1);
    logic step_rnd;
    assign step_rnd = (int'(rnd_q) % KEY_PERIOD) == KEY_PHASE;

    // R1
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && start) |=> (run_q && rnd_q == '0 && chal_q == $past(challenge)));
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !run_q);
    // R2
    last_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && rnd_q == LAST_RND) |=> done);
    // R8
    ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && rnd_q != LAST_RND) |=> (run_q && rnd_q == CNTW'($past(rnd_q) + 1'b1)));
    // R3
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> (chal_q[CW-3:0] == $past(chal_q[CW-1:2])));
    // R5
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !step_rnd) |=> $stable(key_q));
    // R5
    key_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && step_rnd) |=> (key_q == {$past(key_q[KW-2:0]),
            $past(key_q[TAP_A] ^ key_q[TAP_B] ^ key_q[TAP_C] ^ key_q[TAP_D])}));
    // R6
    zero_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && key_q == '0) |=> (key_q == '0));
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !start) |=> $stable(chal_q));
endmodule

bind fsr_cipher_core fsrc_checker #(
    .CNTW       (CNTW),
    .ROUNDS     (ROUNDS),
    .KEY_PERIOD (KEY_PERIOD),
    .KEY_PHASE  (KEY_PHASE)
) i_fsrc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .challenge (challenge),
    .done      (done),
    .run_q     (run_q),
    .rnd_q     (rnd_q),
    .key_q     (key_q),
    .chal_q    (chal_q)
);

// File: tb/test_fsr_cipher_core.sv
module test_fsr_cipher_core;
    import fsrc_pkg::*;

    localparam int RESP_W = 24;
    localparam int ROUNDS = 200;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [KW-1:0]     key_in = '0;
    logic [CW-1:0]     challenge = '0;
    logic              done;
    logic [RESP_W-1:0] response;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    fsr_cipher_core i_fsr_cipher_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .key_in    (key_in),
        .challenge (challenge),
        .done      (done),
        .response  (response)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    function automatic logic [1:0] model_rf(logic [KW-1:0] k, logic [CW-1:0] c);
        logic [VEC_W-1:0] v;
        logic [NLEAF-1:0] l;
        logic [NMID-1:0]  g;
        logic [LEAF_TW-1:0] ltt;
        logic [MID_TW-1:0]  mtt;
        v = {k, c};
        for (int i = 0; i < NLEAF; i++) begin
            logic [LEAF_IN-1:0] a;
            for (int j = 0; j < LEAF_IN; j++)
                a[j] = (j == LEAF_IN - 1 && FOUR_IN_DEF[i]) ? 1'b0 : v[route_of(i, j)];
            ltt  = leaf_tt_of(i);
            l[i] = ltt[a];
        end
        for (int m = 0; m < NMID; m++) begin
            mtt  = mid_tt_of(m);
            g[m] = mtt[l[4*m +: 4]];
        end
        return FIN_TT_DEF[2*int'(g) +: 2];
    endfunction

    function automatic logic [RESP_W-1:0] model(logic [KW-1:0] k0, logic [CW-1:0] c0);
        logic [KW-1:0] k;
        logic [CW-1:0] c;
        logic [1:0] y;
        k = k0;
        c = c0;
        for (int r = 0; r < ROUNDS; r++) begin
            y = model_rf(k, c);
            c = {y[1] ^ c[39], y[0] ^ c[38], c[39:2]};
            if (r % 3 == 1) k = {k[38:0], k[39] ^ k[37] ^ k[20] ^ k[18]};
        end
        return c[RESP_W-1:0];
    endfunction

    // Called at a negedge; returns at the negedge on which done is seen.
    task automatic run(input logic [KW-1:0] k, input logic [CW-1:0] c, input int poke_at, input string tag);
        int lat;
        logic [RESP_W-1:0] exp;
        exp = model(k, c);
        key_in = k;
        challenge = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        key_in = ~k;          // R1: later input values must not matter
        challenge = ~c;
        lat = 0;
        while (!done && lat < ROUNDS + 10) begin
            @(negedge clk);
            lat++;
            start = (lat == poke_at);   // R8: strobe during the run
            if (lat == poke_at) challenge = c ^ 40'hA5A5_5A5A_33;
        end
        start = 1'b0;
        check(lat == ROUNDS, {"R2 latency ", tag}, 64'(lat), 64'(ROUNDS));
        check(response == exp, {"R4 R3 R5 R7 response ", tag}, 64'(response), 64'(exp));
    endtask

    task automatic idle_after(input string tag);
        logic [RESP_W-1:0] held;
        held = response;
        @(negedge clk);
        check(done == 1'b0, {"R2 pulse width ", tag}, 64'(done), 64'd0);
        repeat (3) @(negedge clk);
        check(response == held, {"R7 hold ", tag}, 64'(response), 64'(held));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R9 done in reset", 64'(done), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(done == 1'b0, "R9 done after reset", 64'(done), 64'd0);
        check(response == '0, "R9 response after reset", 64'(response), 64'd0);

        // directed corners
        run('0, 40'h12_3456_789A, 0, "zero key R6");
        idle_after("zero key");
        run('0, '0, 0, "zero key zero challenge R6");
        idle_after("all zero");
        run('1, '1, 0, "all ones");
        idle_after("all ones");
        run(40'h80_0000_0001, 40'h00_0000_0001, 0, "single bits");
        idle_after("single bits");
        run(40'hC3_5A96_0F1E, 40'h7E_81DB_2466, 77, "start mid run R8");
        idle_after("start mid run");
        run(40'h01_2345_6789, 40'hFE_DCBA_9876, 1, "start first round R8");
        // back-to-back: start in the done cycle is accepted (R1)
        run(40'h55_AA55_AA55, 40'h0F_F00F_F00F, 0, "back to back R1");
        idle_after("back to back");

        // constrained random runs
        for (int n = 0; n < 14; n++) begin
            logic [KW-1:0] k;
            logic [CW-1:0] c;
            k = {8'($urandom()), 32'($urandom())};
            c = {8'($urandom()), 32'($urandom())};
            if (n % 4 == 3) k[39:20] = '0;
            run(k, c, (n % 3 == 0) ? 1 + int'($urandom() % 198) : 0, "random");
            if (n % 2 == 0) idle_after("random");
        end
        finish_up();
    end
endmodule